// File: doc/BRIEF.md
# Receive Queue Watermark Interrupt Controller

This block tracks how full a receive queue is and turns notable changes into interrupt events. Each cycle it compares the current fill level with the level held from the previous cycle. From that comparison it detects when the level climbs through a programmable high watermark or sinks through a programmable low watermark. Two further event sources come in as single-cycle pulses: one reports that the queue itself overflowed, and the other reports that the FIFO carrying received frames toward external memory overflowed.

Each event is latched into a sticky status register, and software clears that register by reading it. A separate enable register picks which latched events drive the single active-high, level-sensitive interrupt line. The high and low crossing bits sit in opposite positions in the two registers, and the interrupt logic pairs them correctly. Software reaches both registers through a byte-wide read/write port with a combinational read path.

Top module: `qwm_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the status register reads 0x00 and `irq` is low.
- R2: The enable register is at address 0x15C and is readable and writable in bits 3:0. Bit 3 enables FIFO overflow, bit 2 enables queue overflow, bit 1 enables low crossing and bit 0 enables high crossing.
- R3: Status bit 1 sets when `q_level` goes from below `hi_mark` in the previous cycle to at or above `hi_mark` in the current cycle. Holding the level above the mark does not set it again.
- R4: Status bit 0 sets when `q_level` goes from above `lo_mark` in the previous cycle to at or below `lo_mark` in the current cycle. No crossing is detected in the first cycle after reset.
- R5: A pulse on `q_ovf_pulse` sets status bit 2, and a pulse on `fifo_ovf_pulse` sets status bit 3.
- R6: Status bits stay set until the status register at address 0x15D is read. That read returns the latched bits and clears them.
- R7: If an event arrives in the same cycle as a status read, the read returns the value from before the event, and the new event's bit is still set after the read.
- R8: `irq` is high exactly when some status bit is set and its matching enable bit is set. The high crossing (status bit 1) pairs with enable bit 0, and the low crossing (status bit 0) pairs with enable bit 1.
- R9: Bits 7:4 of both registers read as 0. Writes to the status register change nothing. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_level | input | LVL_W | Current receive queue fill level |
| hi_mark | input | LVL_W | High watermark |
| lo_mark | input | LVL_W | Low watermark |
| q_ovf_pulse | input | 1 | One-cycle pulse: queue overflowed |
| fifo_ovf_pulse | input | 1 | One-cycle pulse: receive FIFO overflowed |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a status read clears the status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Active-high level interrupt |

## Verification
The assertions check on every cycle that:
- a latched bit survives any cycle without a status read;
- a read with no coincident event empties the register;
- each detected crossing or overflow pulse shows up in the status on the next cycle, including when it coincides with a read;
- `irq` stays low while nothing is enabled;
- the upper read bits stay zero.

Only the bench's scenarios can show the following:
- that crossings are judged against the previous level and not the absolute level;
- that the swapped high/low pairing between status and enable reaches `irq`;
- that a coincident read returns the old value;
- that writes to the status address and reads of unmapped addresses have no effect.

// File: rtl/qwm_irq_ctrl.sv
module qwm_irq_ctrl #(
  parameter int unsigned LVL_W    = 10,
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned EN_ADDR  = 'h15C,
  parameter int unsigned STS_ADDR = 'h15D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  q_level,
  input  logic [LVL_W-1:0]  hi_mark,
  input  logic [LVL_W-1:0]  lo_mark,
  input  logic              q_ovf_pulse,
  input  logic              fifo_ovf_pulse,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_ADDR);

  logic [3:0]       en_q, sts_q, ev;
  logic [LVL_W-1:0] lvl_q;
  logic             lvl_vld_q;
  logic             unused_wdata;

  wire en_sel  = (reg_addr == EN_A);
  wire sts_sel = (reg_addr == STS_A);
  wire rd_clr  = reg_rd && sts_sel;

  // crossings judged against last cycle's level
  wire hi_x = lvl_vld_q && (lvl_q < hi_mark) && (q_level >= hi_mark);
  wire lo_x = lvl_vld_q && (lvl_q > lo_mark) && (q_level <= lo_mark);

  // status order: fifo, queue, high, low
  assign ev = {fifo_ovf_pulse, q_ovf_pulse, hi_x, lo_x};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= '0;
      lvl_vld_q <= 1'b0;
      en_q      <= '0;
      sts_q     <= '0;
    end else begin
      lvl_q     <= q_level;
      lvl_vld_q <= 1'b1;
      if (reg_wr && en_sel) en_q <= reg_wdata[3:0];
      sts_q <= (rd_clr ? 4'b0 : sts_q) | ev;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      if (en_sel)       reg_rdata = {4'b0, en_q};
      else if (sts_sel) reg_rdata = {4'b0, sts_q};
    end
  end

  // enable order: fifo, queue, low, high -> swap the two low bits
  assign irq = |(sts_q & {en_q[3], en_q[2], en_q[0], en_q[1]});

  assign unused_wdata = ^reg_wdata[7:4];

  a_r3_hi_latched: assert property (@(posedge clk) disable iff (!rst_n)
    hi_x |=> sts_q[1]);
  a_r4_lo_latched: assert property (@(posedge clk) disable iff (!rst_n)
    lo_x |=> sts_q[0]);
  a_r5_qovf_latched: assert property (@(posedge clk) disable iff (!rst_n)
    q_ovf_pulse |=> sts_q[2]);
  a_r5_fovf_latched: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf_pulse |=> sts_q[3]);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !q_ovf_pulse && !fifo_ovf_pulse && !hi_x && !lo_x) |=> (sts_q == 4'b0));
  a_r7_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && q_ovf_pulse) |=> sts_q[2]);
  a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 4'b0) |-> !irq);
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'b0);

endmodule

// File: tb/qwm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module qwm_irq_ctrl_tb;
  localparam int LW = 10;
  localparam logic [8:0] A_EN  = 9'h15C;
  localparam logic [8:0] A_STS = 9'h15D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] q_level = 20, hi_mark = 40, lo_mark = 10;
  logic q_ovf_pulse = 0, fifo_ovf_pulse = 0;
  logic [8:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qwm_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .q_level(q_level), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .q_ovf_pulse(q_ovf_pulse), .fifo_ovf_pulse(fifo_ovf_pulse), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // {level, queue ovf, fifo ovf, expected status}; hi=40, lo=10
  localparam logic [15:0] VEC [0:13] = '{
    {10'd30, 2'b00, 4'h0}, {10'd40, 2'b00, 4'h2}, {10'd50, 2'b00, 4'h0},
    {10'd39, 2'b00, 4'h0}, {10'd60, 2'b00, 4'h2}, {10'd11, 2'b00, 4'h0},
    {10'd10, 2'b00, 4'h1}, {10'd5,  2'b00, 4'h0}, {10'd45, 2'b00, 4'h2},
    {10'd0,  2'b00, 4'h1}, {10'd20, 2'b10, 4'h4}, {10'd20, 2'b01, 4'h8},
    {10'd50, 2'b11, 4'hE}, {10'd10, 2'b00, 4'h1}};

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_q();
    q_ovf_pulse = 1'b1; step(); q_ovf_pulse = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    step();
    rd(A_EN, d);  chk("R1 enable reset", d, 8'h00);
    rd(A_STS, d); chk("R1 status reset", d, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);

    for (int i = 0; i < 14; i++) begin
      q_level = VEC[i][15:6]; q_ovf_pulse = VEC[i][5]; fifo_ovf_pulse = VEC[i][4];
      step();
      q_ovf_pulse = 1'b0; fifo_ovf_pulse = 1'b0;
      rd(A_STS, d);
      chk($sformatf("R3 R4 R5 vector %0d", i), d, {4'b0, VEC[i][3:0]});
    end

    wr(A_EN, 8'hFF); rd(A_EN, d); chk("R2 R9 enable readback", d, 8'h0F);
    wr(A_EN, 8'h02);
    q_level = 45; step();
    chk("R8 high event masked by low enable", {7'b0, irq}, 8'h00);
    q_level = 5; step();
    chk("R8 low event with low enable", {7'b0, irq}, 8'h01);
    rd(A_STS, d); chk("R6 both crossings held", d, 8'h03);
    chk("R8 irq drops after read", {7'b0, irq}, 8'h00);
    wr(A_EN, 8'h01);
    q_level = 45; step();
    chk("R8 high event with high enable", {7'b0, irq}, 8'h01);
    rd(A_STS, d); chk("R3 high latched", d, 8'h02);
    q_level = 50; step(); q_level = 60; step();
    rd(A_STS, d); chk("R3 no retrigger above mark", d, 8'h00);

    wr(A_EN, 8'h04);
    pulse_q();
    chk("R2 queue overflow enable", {7'b0, irq}, 8'h01);
    repeat (5) step();
    rd(A_STS, d); chk("R6 sticky across idle", d, 8'h04);
    rd(A_STS, d); chk("R6 cleared by read", d, 8'h00);

    fifo_ovf_pulse = 1'b1; step(); fifo_ovf_pulse = 1'b0;
    q_ovf_pulse = 1'b1; rd(A_STS, d); q_ovf_pulse = 1'b0;
    chk("R7 coincident read old value", d, 8'h08);
    rd(A_STS, d); chk("R7 coincident event kept", d, 8'h04);

    pulse_q();
    wr(A_STS, 8'hFF);
    rd(A_STS, d); chk("R9 status write ignored", d, 8'h04);
    rd(9'h000, d); chk("R9 unmapped read", d, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule